// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Sequencer

This block holds the architectural register state of a 32-bit processor core: sixteen visible registers, the current status word and one saved status word for each privileged mode that owns one. Two combinational read ports and one write port take a 4-bit register number. The current operating mode picks which physical copy of that register is used. Index 15 is the program counter.

The block also runs the exception sequence. When an unmasked request is raised, one clock edge performs every step of entry. The old status goes into the saved slot of the target mode. The core switches to that mode, leaves the 16-bit state, and masks the normal interrupt (and the fast interrupt too, for fast-interrupt entry). The supplied return address goes into the target mode's register 14, and the program counter takes the vector address. A flag-setting write to index 15 acts as the exception return: it restores the status word from the saved copy.

Instruction decode, the ALU and memory live outside the block. The pipeline hands over operands, return addresses and request lines.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x000000D3 (flags zero, I=1, F=1, T=0, Supervisor mode 10011). It sets every saved status word to the same value and the program counter to VEC_BASE.
- R2: Mode encodings: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011, System 11111. Registers 0 to 7 are shared by all modes. FIQ mode has private copies of registers 8 to 14. IRQ, Supervisor, Abort and Undefined modes each have private registers 13 and 14. System mode uses the User set.
- R3: Both read ports return, in the same cycle, the mode-selected copy of the register they address, independently of each other. Index 15 returns the program counter.
- R4: A write to index 15 loads the program counter with bits 1:0 cleared when T=0, or with bit 0 cleared when T=1. T is taken from the status that holds after that cycle.
- R5: On entry, the block stores the old status in the target mode's saved word and loads the target mode into bits 4:0. It clears T (bit 5) and sets I (bit 7). It sets F (bit 6) only on fast-interrupt entry and leaves the flags (bits 31:28) unchanged. `exc_ret_addr` goes into the target mode's register 14.
- R6: Request bits and results, given as bit: vector offset from VEC_BASE, target mode. Bit 0 undefined instruction: 0x04, Undefined. Bit 1 software interrupt: 0x08, Supervisor. Bit 2 prefetch abort: 0x0C, Abort. Bit 3 data abort: 0x10, Abort. Bit 4 IRQ: 0x18, IRQ. Bit 5 FIQ: 0x1C, FIQ.
- R7: When several requests are raised at once, the winner follows this order: data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R8: An IRQ request is ignored while I=1, and an FIQ request is ignored while F=1. A masked request never blocks a lower-priority request.
- R9: In a cycle that takes an exception, the register write and the status write presented in that cycle have no effect.
- R10: A write to index 15 with `wr_setflags` high copies the saved status into the current status in a mode that has a saved word. In User or System mode the status is left unchanged. The restore takes precedence over a same-cycle current-status write.
- R11: `saved_status` shows the current mode's saved word. In User or System mode it shows the current status, and a saved-status write there is ignored.
- R12: Status writes keep only bits 31:28 and 7:0, and bits 27:8 read as zero. A written mode field that is not one of the seven encodings leaves the stored mode unchanged, while the other fields are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| wr_setflags | input | 1 | Write to index 15 also restores status |
| sr_wr_en | input | 1 | Status write enable |
| sr_wr_sel | input | 1 | 0 writes current status, 1 writes saved status |
| sr_wr_data | input | 32 | Status write data |
| exc_req | input | 6 | Exception request lines (bit map in R6) |
| exc_ret_addr | input | 32 | Return address stored on entry |
| cpsr | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode |
| pc | output | 32 | Program counter |

## Verification
A wrong bank mapping shows up the moment a register is read back from a mode other than the one that wrote it. That is why every index is written from all seven modes and read back from all seven. A wrong entry or priority decision is visible one edge after the request, on `pc`, `cpsr` and `saved_status` together. The bench therefore sweeps all 64 request patterns under all four mask settings. A bad restore or a lost saved word appears on the first flag-setting write to index 15 after entry.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

    localparam int XLEN      = 32;
    localparam int IDX_W     = 4;
    localparam int NUM_REQ   = 6;
    localparam int NUM_PHYS  = 30;
    localparam int PHYS_W    = $clog2(NUM_PHYS);
    localparam int NUM_SAVED = 5;
    localparam int SLOT_W    = $clog2(NUM_SAVED);
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(15);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(14);

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    localparam int REQ_UND  = 0;
    localparam int REQ_SWI  = 1;
    localparam int REQ_PABT = 2;
    localparam int REQ_DABT = 3;
    localparam int REQ_IRQ  = 4;
    localparam int REQ_FIQ  = 5;

    typedef struct packed {
        logic        n;
        logic        z;
        logic        c;
        logic        v;
        logic [19:0] rsvd;
        logic        i;
        logic        f;
        logic        t;
        logic [4:0]  mode;
    } status_t;

    localparam status_t RESET_STATUS = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0,
                                         rsvd: '0, i: 1'b1, f: 1'b1, t: 1'b0,
                                         mode: MODE_SVC};

    typedef enum logic [2:0] {
        EXC_NONE, EXC_UND, EXC_SWI, EXC_PABT, EXC_DABT, EXC_IRQ, EXC_FIQ
    } exc_kind_e;

    function automatic logic mode_legal(input logic [4:0] m);
        return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
               (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_SYS);
    endfunction

    function automatic logic has_saved(input logic [4:0] m);
        return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
               (m == MODE_ABT) || (m == MODE_UND);
    endfunction

    function automatic logic [SLOT_W-1:0] saved_slot(input logic [4:0] m);
        case (m)
            MODE_FIQ: return SLOT_W'(0);
            MODE_IRQ: return SLOT_W'(1);
            MODE_SVC: return SLOT_W'(2);
            MODE_ABT: return SLOT_W'(3);
            MODE_UND: return SLOT_W'(4);
            default:  return SLOT_W'(0);
        endcase
    endfunction

    // Physical layout: 0..14 shared/User, 15..21 fast bank r8..r14,
    // then r13/r14 pairs for IRQ, Supervisor, Abort, Undefined.
    function automatic logic [PHYS_W-1:0] phys_slot(input logic [4:0] m,
                                                    input logic [IDX_W-1:0] idx);
        logic [PHYS_W-1:0] pair_base;
        logic              paired;
        paired    = 1'b1;
        pair_base = PHYS_W'(22);
        case (m)
            MODE_IRQ: pair_base = PHYS_W'(22);
            MODE_SVC: pair_base = PHYS_W'(24);
            MODE_ABT: pair_base = PHYS_W'(26);
            MODE_UND: pair_base = PHYS_W'(28);
            default:  paired = 1'b0;
        endcase
        if (idx == PC_IDX)
            return '0;
        if ((m == MODE_FIQ) && (idx >= IDX_W'(8)))
            return PHYS_W'(15) + PHYS_W'(idx - IDX_W'(8));
        if (paired && (idx >= IDX_W'(13)))
            return pair_base + PHYS_W'(idx - IDX_W'(13));
        return PHYS_W'(idx);
    endfunction

    function automatic logic [4:0] exc_target(input exc_kind_e k);
        case (k)
            EXC_UND:  return MODE_UND;
            EXC_SWI:  return MODE_SVC;
            EXC_PABT: return MODE_ABT;
            EXC_DABT: return MODE_ABT;
            EXC_IRQ:  return MODE_IRQ;
            EXC_FIQ:  return MODE_FIQ;
            default:  return MODE_SVC;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] exc_offset(input exc_kind_e k);
        case (k)
            EXC_UND:  return XLEN'(32'h04);
            EXC_SWI:  return XLEN'(32'h08);
            EXC_PABT: return XLEN'(32'h0C);
            EXC_DABT: return XLEN'(32'h10);
            EXC_IRQ:  return XLEN'(32'h18);
            EXC_FIQ:  return XLEN'(32'h1C);
            default:  return '0;
        endcase
    endfunction

    function automatic status_t merge_status(input status_t old_s,
                                             input logic [XLEN-1:0] d);
        status_t r;
        r      = '0;
        r.n    = d[31];
        r.z    = d[30];
        r.c    = d[29];
        r.v    = d[28];
        r.i    = d[7];
        r.f    = d[6];
        r.t    = d[5];
        r.mode = mode_legal(d[4:0]) ? d[4:0] : old_s.mode;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] align_pc(input logic [XLEN-1:0] v,
                                                 input logic thumb);
        return thumb ? {v[XLEN-1:1], 1'b0} : {v[XLEN-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/bank_rf_exc_arb.sv
module bank_rf_exc_arb
    import bank_rf_pkg::*;
(
    input  logic [NUM_REQ-1:0] req,
    input  logic               irq_masked,
    input  logic               fiq_masked,
    output exc_kind_e          kind
);
    logic [NUM_REQ-1:0] live;

    always_comb begin
        live           = req;
        live[REQ_IRQ]  = req[REQ_IRQ] & ~irq_masked;
        live[REQ_FIQ]  = req[REQ_FIQ] & ~fiq_masked;
        if (live[REQ_DABT])      kind = EXC_DABT;
        else if (live[REQ_FIQ])  kind = EXC_FIQ;
        else if (live[REQ_IRQ])  kind = EXC_IRQ;
        else if (live[REQ_PABT]) kind = EXC_PABT;
        else if (live[REQ_UND])  kind = EXC_UND;
        else if (live[REQ_SWI])  kind = EXC_SWI;
        else                     kind = EXC_NONE;
    end
endmodule

// File: rtl/bank_rf_gpr_store.sv
module bank_rf_gpr_store #(
    parameter int NUM = 30,
    parameter int W   = 32,
    parameter int AW  = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wslot,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] rslot_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] rslot_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we && (wslot == AW'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[rslot_a];
    assign rdata_b = regs[rslot_b];
endmodule

// File: rtl/bank_rf_status.sv
module bank_rf_status
    import bank_rf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  exc_kind_e       kind,
    input  logic            restore,
    input  logic            sr_wr_en,
    input  logic            sr_wr_sel,
    input  logic [XLEN-1:0] sr_wr_data,
    output status_t         cur_q,
    output status_t         cur_d,
    output status_t         saved_view
);
    status_t           saved_q [NUM_SAVED];
    status_t           saved_d [NUM_SAVED];
    logic              cur_has;
    logic [SLOT_W-1:0] cur_slot;
    logic [4:0]        tgt;

    assign cur_has  = has_saved(cur_q.mode);
    assign cur_slot = saved_slot(cur_q.mode);
    assign tgt      = exc_target(kind);

    always_comb begin
        cur_d   = cur_q;
        saved_d = saved_q;
        if (kind != EXC_NONE) begin
            saved_d[saved_slot(tgt)] = cur_q;
            cur_d.mode = tgt;
            cur_d.t    = 1'b0;
            cur_d.i    = 1'b1;
            if (kind == EXC_FIQ)
                cur_d.f = 1'b1;
        end else begin
            if (restore && cur_has)
                cur_d = saved_q[cur_slot];
            else if (sr_wr_en && !sr_wr_sel)
                cur_d = merge_status(cur_q, sr_wr_data);
            if (sr_wr_en && sr_wr_sel && cur_has)
                saved_d[cur_slot] = merge_status(saved_q[cur_slot], sr_wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= RESET_STATUS;
            for (int k = 0; k < NUM_SAVED; k++)
                saved_q[k] <= RESET_STATUS;
        end else begin
            cur_q <= cur_d;
            for (int k = 0; k < NUM_SAVED; k++)
                saved_q[k] <= saved_d[k];
        end
    end

    assign saved_view = cur_has ? saved_q[cur_slot] : cur_q;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_rf_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_a_idx,
    output logic [XLEN-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]   rd_b_idx,
    output logic [XLEN-1:0]    rd_b_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [XLEN-1:0]    wr_data,
    input  logic               wr_setflags,
    input  logic               sr_wr_en,
    input  logic               sr_wr_sel,
    input  logic [XLEN-1:0]    sr_wr_data,
    input  logic [NUM_REQ-1:0] exc_req,
    input  logic [XLEN-1:0]    exc_ret_addr,
    output logic [XLEN-1:0]    cpsr,
    output logic [XLEN-1:0]    saved_status,
    output logic [XLEN-1:0]    pc
);
    status_t           cur_q, cur_d, saved_view;
    exc_kind_e         kind;
    logic              pc_write, restore;
    logic              g_we;
    logic [PHYS_W-1:0] g_wslot;
    logic [XLEN-1:0]   g_wdata;
    logic [XLEN-1:0]   gpr_a, gpr_b;
    logic [XLEN-1:0]   pc_q;

    assign pc_write = wr_en && (wr_idx == PC_IDX);
    assign restore  = pc_write && wr_setflags;

    bank_rf_exc_arb u_arb (
        .req        (exc_req),
        .irq_masked (cur_q.i),
        .fiq_masked (cur_q.f),
        .kind       (kind)
    );

    bank_rf_status u_status (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .restore    (restore),
        .sr_wr_en   (sr_wr_en),
        .sr_wr_sel  (sr_wr_sel),
        .sr_wr_data (sr_wr_data),
        .cur_q      (cur_q),
        .cur_d      (cur_d),
        .saved_view (saved_view)
    );

    always_comb begin
        g_we    = 1'b0;
        g_wslot = '0;
        g_wdata = wr_data;
        if (kind != EXC_NONE) begin
            g_we    = 1'b1;
            g_wslot = phys_slot(exc_target(kind), LR_IDX);
            g_wdata = exc_ret_addr;
        end else if (wr_en && !pc_write) begin
            g_we    = 1'b1;
            g_wslot = phys_slot(cur_q.mode, wr_idx);
        end
    end

    bank_rf_gpr_store #(
        .NUM (NUM_PHYS),
        .W   (XLEN),
        .AW  (PHYS_W)
    ) u_store (
        .clk     (clk),
        .we      (g_we && !rst),
        .wslot   (g_wslot),
        .wdata   (g_wdata),
        .rslot_a (phys_slot(cur_q.mode, rd_a_idx)),
        .rdata_a (gpr_a),
        .rslot_b (phys_slot(cur_q.mode, rd_b_idx)),
        .rdata_b (gpr_b)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= VEC_BASE;
        else if (kind != EXC_NONE)
            pc_q <= VEC_BASE + exc_offset(kind);
        else if (pc_write)
            pc_q <= align_pc(wr_data, cur_d.t);
    end

    assign rd_a_data    = (rd_a_idx == PC_IDX) ? pc_q : gpr_a;
    assign rd_b_data    = (rd_b_idx == PC_IDX) ? pc_q : gpr_b;
    assign cpsr         = cur_q;
    assign saved_status = saved_view;
    assign pc           = pc_q;
endmodule

// File: rtl/bank_rf_checker.sv
module bank_rf_checker
    import bank_rf_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               wr_setflags,
    input logic               sr_wr_en,
    input logic [NUM_REQ-1:0] exc_req,
    input logic [XLEN-1:0]    cpsr,
    input logic [XLEN-1:0]    pc
);
    logic take;
    logic plain_mode;

    assign take = exc_req[REQ_DABT] | exc_req[REQ_PABT] | exc_req[REQ_UND] |
                  exc_req[REQ_SWI] | (exc_req[REQ_IRQ] & ~cpsr[7]) |
                  (exc_req[REQ_FIQ] & ~cpsr[6]);
    assign plain_mode = (cpsr[4:0] == MODE_USR) || (cpsr[4:0] == MODE_SYS);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cpsr == 32'h0000_00D3) && (pc == VEC_BASE));

    p_pc_even_r4: assert property (@(posedge clk) disable iff (rst)
        pc[0] == 1'b0);

    p_mode_legal_r12: assert property (@(posedge clk) disable iff (rst)
        mode_legal(cpsr[4:0]));

    p_entry_masks_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> (cpsr[7] && !cpsr[5]));

    p_fiq_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (exc_req[REQ_FIQ] && !cpsr[6] && !exc_req[REQ_DABT])
        |=> (cpsr[4:0] == MODE_FIQ) && cpsr[6] && (pc == VEC_BASE + 32'h1C));

    p_dabt_wins_r7: assert property (@(posedge clk) disable iff (rst)
        exc_req[REQ_DABT] |=> (cpsr[4:0] == MODE_ABT) && (pc == VEC_BASE + 32'h10));

    p_masked_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_req == 6'b010000 && cpsr[7] && !sr_wr_en && !wr_en)
        |=> (cpsr == $past(cpsr)));

    p_plain_restore_r10: assert property (@(posedge clk) disable iff (rst)
        (plain_mode && wr_en && (wr_idx == PC_IDX) && wr_setflags && !sr_wr_en && !take)
        |=> (cpsr == $past(cpsr)));
endmodule

bind banked_regfile bank_rf_checker #(.VEC_BASE(VEC_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_setflags (wr_setflags),
    .sr_wr_en    (sr_wr_en),
    .exc_req     (exc_req),
    .cpsr        (cpsr),
    .pc          (pc)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sr_wr_data = '0, exc_ret_addr = '0;
    logic        wr_en = 1'b0, wr_setflags = 1'b0, sr_wr_en = 1'b0, sr_wr_sel = 1'b0;
    logic [5:0]  exc_req = '0;
    logic [31:0] cpsr, saved_status, pc;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                           M_SYS = 5'b11111;
    localparam logic [4:0] MODES [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};

    logic [31:0] m_usr [15];
    logic [31:0] m_fiq [7];
    logic [31:0] m_bnk [4][2];

    always #5 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_setflags(wr_setflags),
        .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data),
        .exc_req(exc_req), .exc_ret_addr(exc_ret_addr),
        .cpsr(cpsr), .saved_status(saved_status), .pc(pc)
    );

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            M_FIQ: return 1;
            M_IRQ: return 2;
            M_SVC: return 3;
            M_ABT: return 4;
            M_UND: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [4:0] m, input int i);
        int b = bank_of(m);
        if (b == 1 && i >= 8) return m_fiq[i-8];
        if (b >= 2 && i >= 13) return m_bnk[b-2][i-13];
        return m_usr[i];
    endfunction

    task automatic model_write(input logic [4:0] m, input int i, input logic [31:0] v);
        int b = bank_of(m);
        if (b == 1 && i >= 8) m_fiq[i-8] = v;
        else if (b >= 2 && i >= 13) m_bnk[b-2][i-13] = v;
        else m_usr[i] = v;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int i, input logic [31:0] v, input logic setf);
        wr_en = 1'b1; wr_idx = 4'(i); wr_data = v; wr_setflags = setf;
        tick();
        wr_en = 1'b0; wr_setflags = 1'b0;
    endtask

    task automatic set_sr(input logic sel, input logic [31:0] v);
        sr_wr_en = 1'b1; sr_wr_sel = sel; sr_wr_data = v;
        tick();
        sr_wr_en = 1'b0;
    endtask

    task automatic read_a(input string req, input int i, input logic [31:0] exp);
        rd_a_idx = 4'(i);
        #1;
        chk(req, rd_a_data, exp);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc, exp_sr, v;
        logic [4:0]  tgt;
        @(negedge clk);
        tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 cpsr", cpsr, 32'h0000_00D3);
        chk("R1 pc", pc, 32'h0);
        chk("R1 saved", saved_status, 32'h0000_00D3);
        read_a("R1 r15 read", 15, 32'h0);

        // R2/R3 banking sweep: write every index from every mode
        for (int mi = 0; mi < 7; mi++) begin
            set_sr(1'b0, {24'h0, 3'b110, MODES[mi]});
            for (int i = 0; i < 15; i++) begin
                v = {8'(mi), 8'(i), 16'hBEEF};
                wr_reg(i, v, 1'b0);
                model_write(MODES[mi], i, v);
            end
        end
        for (int mi = 0; mi < 7; mi++) begin
            set_sr(1'b0, {24'h0, 3'b110, MODES[mi]});
            for (int i = 0; i < 15; i++) begin
                rd_a_idx = 4'(i);
                rd_b_idx = 4'(14 - i);
                #1;
                chk("R2 port A", rd_a_data, model_read(MODES[mi], i));
                chk("R3 port B", rd_b_data, model_read(MODES[mi], 14 - i));
            end
        end

        // R4 pc alignment
        set_sr(1'b0, 32'h0000_00D3);
        wr_reg(15, 32'h0000_1237, 1'b0);
        chk("R4 arm align", pc, 32'h0000_1234);
        read_a("R4 r15 read", 15, 32'h0000_1234);
        set_sr(1'b0, 32'h0000_00F3);
        wr_reg(15, 32'h0000_1237, 1'b0);
        chk("R4 thumb align", pc, 32'h0000_1236);

        // R5/R6 entry per exception kind, then R10 return
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin tgt = M_UND; exp_pc = 32'h04; end
                1: begin tgt = M_SVC; exp_pc = 32'h08; end
                2: begin tgt = M_ABT; exp_pc = 32'h0C; end
                3: begin tgt = M_ABT; exp_pc = 32'h10; end
                4: begin tgt = M_IRQ; exp_pc = 32'h18; end
                default: begin tgt = M_FIQ; exp_pc = 32'h1C; end
            endcase
            set_sr(1'b0, 32'hA000_0030);
            exc_req = 6'(1 << k);
            exc_ret_addr = 32'h4000_0000 + 32'(k * 4);
            tick();
            exc_req = '0;
            model_write(tgt, 14, exc_ret_addr);
            chk("R5 cpsr", cpsr, 32'hA000_0080 | (k == 5 ? 32'h40 : 32'h0) | {27'h0, tgt});
            chk("R5 saved", saved_status, 32'hA000_0030);
            chk("R6 vector", pc, exp_pc);
            read_a("R5 lr", 14, exc_ret_addr);
            wr_reg(15, 32'h0000_0203, 1'b1);
            chk("R10 restore", cpsr, 32'hA000_0030);
            chk("R4 restore align", pc, 32'h0000_0202);
            read_a("R2 user lr", 14, model_read(M_USR, 14));
        end

        // R7/R8 exhaustive request sweep under every mask setting
        for (int msk = 0; msk < 4; msk++) begin
            for (int p = 0; p < 64; p++) begin
                set_sr(1'b0, {24'h0, 1'(msk >> 1), 1'(msk), 1'b0, M_USR});
                wr_reg(15, 32'h0000_0100, 1'b0);
                exc_req = 6'(p);
                tick();
                exc_req = '0;
                exp_pc = 32'h100;
                exp_sr = {24'h0, 1'(msk >> 1), 1'(msk), 1'b0, M_USR};
                tgt = 5'b0;
                if (p[3]) begin tgt = M_ABT; exp_pc = 32'h10; end
                else if (p[5] && !msk[0]) begin tgt = M_FIQ; exp_pc = 32'h1C; end
                else if (p[4] && !msk[1]) begin tgt = M_IRQ; exp_pc = 32'h18; end
                else if (p[2]) begin tgt = M_ABT; exp_pc = 32'h0C; end
                else if (p[0]) begin tgt = M_UND; exp_pc = 32'h04; end
                else if (p[1]) begin tgt = M_SVC; exp_pc = 32'h08; end
                if (tgt != 5'b0)
                    exp_sr = {24'h0, 1'b1, (msk[0] || tgt == M_FIQ), 1'b0, tgt};
                chk("R7 pc", pc, exp_pc);
                chk("R8 cpsr", cpsr, exp_sr);
            end
        end

        // R9 same-cycle writes dropped on entry
        set_sr(1'b0, 32'h0000_0010);
        wr_reg(0, 32'h1111_1111, 1'b0);
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h2222_2222;
        sr_wr_en = 1'b1; sr_wr_sel = 1'b0; sr_wr_data = 32'h0000_001F;
        exc_req = 6'b000001; exc_ret_addr = 32'h0000_5550;
        tick();
        wr_en = 1'b0; sr_wr_en = 1'b0; exc_req = '0;
        chk("R9 cpsr", cpsr, 32'h0000_0080 | {27'h0, M_UND});
        read_a("R9 r0 kept", 0, 32'h1111_1111);

        // R10 no restore in User/System
        set_sr(1'b0, 32'h6000_0010);
        wr_reg(15, 32'h0000_0301, 1'b1);
        chk("R10 user", cpsr, 32'h6000_0010);
        chk("R4 user pc", pc, 32'h0000_0300);
        set_sr(1'b0, 32'h6000_001F);
        wr_reg(15, 32'h0000_0305, 1'b1);
        chk("R10 system", cpsr, 32'h6000_001F);

        // R11 saved view and ignored write
        set_sr(1'b0, 32'h0000_00D3);
        set_sr(1'b1, 32'h1000_00D1);
        chk("R11 svc saved", saved_status, 32'h1000_00D1);
        set_sr(1'b0, 32'h0000_0010);
        chk("R11 user view", saved_status, 32'h0000_0010);
        set_sr(1'b1, 32'h2000_00DF);
        chk("R11 user view after write", saved_status, 32'h0000_0010);
        set_sr(1'b0, 32'h0000_00D3);
        chk("R11 svc untouched", saved_status, 32'h1000_00D1);

        // R12 field masking and illegal mode
        set_sr(1'b0, 32'h5FFF_FF15);
        chk("R12 cpsr", cpsr, 32'h5000_0013);
        set_sr(1'b1, 32'h8000_0004);
        chk("R12 saved", saved_status, 32'h8000_0011);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule